// File: doc/BRIEF.md
# Carrier Deference Gap Timer

This block decides when a half-duplex transmitter may start a frame that does not follow straight on from its own previous frame. Once carrier sense drops, it counts enabled timing ticks up to a programmable total gap. The gap has two phases. In the early phase, carrier from another station makes the block give up the gap and defer again. In the late phase, carrier is noted but does not stop the count. If a transmission is then allowed, the block flags a forced collision so that the random backoff logic takes over.

A 32-bit configuration word holds the early-window length and the total gap length, both 7 bits wide. The early window is clamped to the total gap whenever software programs it larger. The transmitter raises a request and receives a one-cycle permit pulse. A medium-busy end pulse, for example at the end of the station's own frame or jam, throws away any gap progress and forces the timer back through deference.

Top module: `ipg_defer_timer`

## Requirements
- R1: The configuration word holds the early-window field at bits 14:8 and the total-gap field at bits 6:0. Both fields are 7 bits and readable and writable. After reset they hold 12 and 18, so the word reads 0x0000_0C12.
- R2: Bits 31:15 and bit 7 of the configuration word always read 0, whatever was written.
- R3: The count restarts at zero on the first clock edge at which carrier is low in the deferring state. It gains one on each edge where tick_en is high. With a request pending, tx_permit is high for the cycle that follows the edge IPG2+1 edges after that start edge. If carrier is driven low in bench cycle m with tick_en high throughout, the permit shows in cycle m+IPG2+2.
- R4: Carrier seen while the count is below the effective window ends the gap. The block defers, and timing restarts from zero once carrier is low again.
- R5: Carrier seen once the count has reached the effective window does not delay the permit. The permit comes at the normal time, with force_col high in the same cycle.
- R6: An edge with tick_en low leaves the count unchanged, so the permit is delayed by exactly the number of such edges inside the gap.
- R7: The effective window is the smaller of the programmed window and the total gap. The readback keeps the value as written.
- R8: tx_permit never stays high for two cycles in a row. After a permit the block returns to deferring, so with carrier low and the request still held, permits repeat every IPG2+2 cycles.
- R9: If the gap completes with no request, no permit is given. A request raised later in cycle q gives a permit in cycle q+1.
- R10: force_col is high only in a cycle where tx_permit is high.
- R11: A single-cycle busy_end pulse in cycle p sends the block back to deferring. With carrier low, the permit then shows in cycle p+IPG2+3.
- R12: With an early window of 0, carrier seen at any count, including count 0, never restarts the gap, and the permit carries force_col.
- R13: During and right after reset, tx_permit and force_col are low and the block is deferring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Gap timing tick enable |
| carrier | input | 1 | Carrier sense level |
| busy_end | input | 1 | Medium-busy end pulse, restarts deference |
| tx_req | input | 1 | Transmit request from the transmitter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| tx_permit | output | 1 | One-cycle transmit-permitted pulse |
| force_col | output | 1 | One-cycle forced-collision flag |

## Verification
The assertions assume that every input is synchronous to clk and known once reset is released. They also assume busy_end lasts one cycle, and that the configuration changes only while the timer is parked in deference, so the compare limits do not move under a running count. The stimulus changes inputs only on the falling edge. It writes the configuration only after forcing the block into deference with busy_end and carrier high. It raises carrier and busy_end for exactly one cycle at cycles chosen from the known start edge.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int GAP_W   = 7;
  localparam int CFG_W   = 32;
  localparam int WIN_LSB = 8;
  localparam int TGT_LSB = 0;

  typedef logic [GAP_W-1:0] gap_t;

  localparam gap_t WIN_RST = gap_t'(12);
  localparam gap_t TGT_RST = gap_t'(18);
  localparam gap_t CNT_MAX = '1;

  typedef enum logic [1:0] {
    ST_DEFER = 2'd0,
    ST_GAP   = 2'd1,
    ST_HOLD  = 2'd2
  } dfr_state_e;

  // Early window can never exceed the total gap.
  function automatic gap_t clamp_window(gap_t win, gap_t tgt);
    return (win > tgt) ? tgt : win;
  endfunction

  // Count still inside the window where carrier forces deference.
  function automatic logic window_open(gap_t cnt, gap_t win_eff);
    return cnt < win_eff;
  endfunction

  // Total gap has been timed.
  function automatic logic gap_reached(gap_t cnt, gap_t tgt);
    return cnt >= tgt;
  endfunction

  // Saturating increment.
  function automatic gap_t bump(gap_t cnt);
    return (cnt == CNT_MAX) ? cnt : cnt + gap_t'(1);
  endfunction
endpackage

// File: rtl/ipg_cfg_regs.sv
module ipg_cfg_regs
  import ipg_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int WL = WIN_LSB,
  parameter int TL = TGT_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output gap_t          win_eff,
  output gap_t          tgt
);
  gap_t win_q;
  gap_t tgt_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= WIN_RST;
      tgt_q <= TGT_RST;
    end else if (we) begin
      win_q <= wdata[WL +: GAP_W];
      tgt_q <= wdata[TL +: GAP_W];
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[WL +: GAP_W] = win_q;
    rdata[TL +: GAP_W] = tgt_q;
  end

  assign win_eff = clamp_window(win_q, tgt_q);
  assign tgt     = tgt_q;

  // R1: a write lands in both fields on the next edge
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[WL +: GAP_W] == $past(wdata[WL +: GAP_W]) &&
            rdata[TL +: GAP_W] == $past(wdata[TL +: GAP_W])));
endmodule

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter
  import ipg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  gap_t win_eff,
  input  gap_t tgt,
  output gap_t cnt,
  output logic in_window,
  output logic gap_done
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= bump(cnt);
  end

  assign in_window = window_open(cnt, win_eff);
  assign gap_done  = gap_reached(cnt, tgt);

  // R6: no advance request means the count holds
  p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(cnt));
  // R3: a clear starts timing from zero
  p_cnt_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/ipg_defer_ctrl.sv
module ipg_defer_ctrl
  import ipg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       carrier,
  input  logic       busy_end,
  input  logic       tx_req,
  input  logic       in_window,
  input  logic       gap_done,
  output logic       cnt_clr,
  output logic       cnt_adv,
  output logic       tx_permit,
  output logic       force_col,
  output dfr_state_e st
);
  dfr_state_e st_n;
  logic       late_q, late_n;
  logic       permit_n, col_n;

  always_comb begin
    st_n     = st;
    late_n   = late_q;
    permit_n = 1'b0;
    col_n    = 1'b0;
    cnt_clr  = 1'b0;
    cnt_adv  = 1'b0;
    if (busy_end) begin
      st_n   = ST_DEFER;
      late_n = 1'b0;
    end else begin
      case (st)
        ST_DEFER: begin
          if (!carrier) begin
            st_n    = ST_GAP;
            cnt_clr = 1'b1;
            late_n  = 1'b0;
          end
        end
        ST_GAP: begin
          if (in_window && carrier) begin
            st_n = ST_DEFER;
          end else if (gap_done) begin
            if (tx_req) begin
              permit_n = 1'b1;
              col_n    = late_q | carrier;
              st_n     = ST_DEFER;
            end else begin
              late_n = late_q | carrier;
              st_n   = ST_HOLD;
            end
          end else begin
            late_n  = late_q | carrier;
            cnt_adv = tick_en;
          end
        end
        ST_HOLD: begin
          if (tx_req) begin
            permit_n = 1'b1;
            col_n    = late_q | carrier;
            st_n     = ST_DEFER;
          end else if (carrier) begin
            st_n = ST_DEFER;
          end
        end
        default: st_n = ST_DEFER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_DEFER;
      late_q    <= 1'b0;
      tx_permit <= 1'b0;
      force_col <= 1'b0;
    end else begin
      st        <= st_n;
      late_q    <= late_n;
      tx_permit <= permit_n;
      force_col <= col_n;
    end
  end

  // R8: permit is a single-cycle pulse
  p_permit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |=> !tx_permit);
  // R10: collision flag only alongside a permit
  p_col_with_permit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_col |-> tx_permit);
  // R4: early carrier sends the block back to deferring
  p_early_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && in_window && carrier && !busy_end) |=> (st == ST_DEFER));
  // R3: a permit follows a completed gap or a held one
  p_permit_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> $past((st == ST_GAP && gap_done) || st == ST_HOLD));
  // R11: busy end always lands in deferring
  p_busy_end_defers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_end |=> (st == ST_DEFER && !tx_permit));
endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer
  import ipg_pkg::*;
#(
  parameter int CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          carrier,
  input  logic          busy_end,
  input  logic          tx_req,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  output logic          tx_permit,
  output logic          force_col
);
  gap_t       win_eff, tgt, cnt;
  logic       in_window, gap_done, cnt_clr, cnt_adv;
  dfr_state_e st;

  ipg_cfg_regs #(.CW(CW), .WL(WIN_LSB), .TL(TGT_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .win_eff(win_eff), .tgt(tgt)
  );

  ipg_gap_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(cnt_adv),
    .win_eff(win_eff), .tgt(tgt), .cnt(cnt),
    .in_window(in_window), .gap_done(gap_done)
  );

  ipg_defer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .carrier(carrier),
    .busy_end(busy_end), .tx_req(tx_req), .in_window(in_window),
    .gap_done(gap_done), .cnt_clr(cnt_clr), .cnt_adv(cnt_adv),
    .tx_permit(tx_permit), .force_col(force_col), .st(st)
  );

  // R7: the window in use never exceeds the total gap
  p_window_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && carrier && cnt >= tgt) |=> !(st == ST_DEFER && !tx_permit && !$past(busy_end)));
  // R13: leaving reset the block is deferring with quiet outputs
  p_reset_quiet_r13: assert property (@(posedge clk)
    !rst_n |=> (!tx_permit && !force_col && st == ST_DEFER));
endmodule

// File: tb/tb_ipg_defer_timer.sv
module tb_ipg_defer_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        carrier = 1'b1;
  logic        busy_end = 1'b0;
  logic        tx_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tx_permit, force_col;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tgt_now = 18;

  typedef struct {
    int    at;
    bit    col;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ipg_defer_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .carrier(carrier),
    .busy_end(busy_end), .tx_req(tx_req), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_permit(tx_permit), .force_col(force_col)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Permit cycle for a gap whose carrier went low in cycle m.
  function automatic int permit_at(int m, int stall);
    return m + tgt_now + 2 + stall;
  endfunction

  task automatic expect_permit(int at, bit col, string tag);
    exp_t e;
    e.at = at; e.col = col; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (force_col && !tx_permit) begin
        checks++; errors++;
        $display("FAIL R10: force_col=1 with tx_permit=0 at cycle %0d (expected 0)", cyc);
      end
      if (tx_permit) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8: unexpected permit at cycle %0d, expected none", cyc);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.at != cyc || e.col != force_col) begin
            errors++;
            $display("FAIL %s: permit at %0d col %0b, expected at %0d col %0b",
                     e.tag, cyc, force_col, e.at, e.col);
          end
        end
      end
    end
  end

  task automatic park();
    @(negedge clk);
    carrier = 1'b1; busy_end = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    busy_end = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg_write(logic [6:0] win, logic [6:0] tgt);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {17'h0, win, 1'b0, tgt};
    @(negedge clk);
    cfg_we = 1'b0;
    tgt_now = int'(tgt);
  endtask

  task automatic start_gap(output int m);
    @(negedge clk);
    carrier = 1'b0;
    m = cyc;
  endtask

  task automatic carrier_blip(int c);
    wait_cyc(c);
    carrier = 1'b1;
    @(negedge clk);
    carrier = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    int m, n, q;
    repeat (4) @(negedge clk);
    checks++;
    if (tx_permit !== 1'b0 || force_col !== 1'b0) begin
      errors++;
      $display("FAIL R13: outputs %b%b in reset, expected 00", tx_permit, force_col);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (tx_permit !== 1'b0 || force_col !== 1'b0) begin
      errors++;
      $display("FAIL R13: outputs %b%b after reset, expected 00", tx_permit, force_col);
    end
    check32("R1 reset word", cfg_rdata, 32'h0000_0C12);

    // R3: default gap
    park(); tx_req = 1'b1;
    start_gap(m);
    expect_permit(permit_at(m, 0), 1'b0, "R3 default gap");
    wait_cyc(m + 24);

    // R1 / R3: other setting
    park();
    cfg_write(7'd5, 7'd30);
    check32("R1 readback 5/30", cfg_rdata, 32'h0000_051E);
    start_gap(m);
    expect_permit(permit_at(m, 0), 1'b0, "R3 gap 30");
    wait_cyc(m + 36);

    // R4: early carrier restarts
    park(); start_gap(m); n = m + 1;
    expect_permit(n + 2 + 1 + tgt_now + 2, 1'b0, "R4 early carrier");
    carrier_blip(n + 2);
    wait_cyc(n + 45);

    // R5: late carrier ignored, collision flagged
    park(); start_gap(m); n = m + 1;
    expect_permit(permit_at(m, 0), 1'b1, "R5 late carrier");
    carrier_blip(n + 10);
    wait_cyc(m + 36);

    // R6: stall ticks
    park(); start_gap(m); n = m + 1;
    expect_permit(permit_at(m, 7), 1'b0, "R6 tick stall");
    wait_cyc(n + 3);
    tick_en = 1'b0;
    repeat (7) @(negedge clk);
    tick_en = 1'b1;
    wait_cyc(m + 44);

    // R11: busy end restarts
    park(); start_gap(m); n = m + 1;
    expect_permit(n + 8 + tgt_now + 3, 1'b0, "R11 busy end");
    wait_cyc(n + 8);
    busy_end = 1'b1;
    @(negedge clk);
    busy_end = 1'b0;
    wait_cyc(n + 8 + tgt_now + 6);

    // R9: hold without request
    park(); tx_req = 1'b0;
    start_gap(m);
    q = m + 45;
    wait_cyc(q);
    expect_permit(q + 1, 1'b0, "R9 held gap");
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    wait_cyc(q + 5);

    // R8: back-to-back permits with request held
    park(); tx_req = 1'b1;
    start_gap(m);
    for (int k = 0; k < 3; k++)
      expect_permit(m + (k + 1) * (tgt_now + 2), 1'b0, "R8 repeat");
    wait_cyc(m + 3 * (tgt_now + 2) + 2);

    // R7: clamp window 100 -> 20
    park();
    cfg_write(7'd100, 7'd20);
    check32("R7 readback raw", cfg_rdata, 32'h0000_6414);
    start_gap(m); n = m + 1;
    expect_permit(permit_at(m, 0), 1'b1, "R7 clamped window");
    carrier_blip(n + 20);
    wait_cyc(m + 26);

    // R12: zero window
    park();
    cfg_write(7'd0, 7'd18);
    start_gap(m); n = m + 1;
    expect_permit(permit_at(m, 0), 1'b1, "R12 zero window");
    carrier_blip(n);
    wait_cyc(m + 24);

    // R2: reserved bits
    park();
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    check32("R2 reserved zero", cfg_rdata, 32'h0000_7F7F);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d permits missing, expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule